// File: doc/BRIEF.md
# Pipelined burst SRAM control core

This block is the synchronous front end of a single-port 64-bit memory with a small internal array (256 words by default). Address, write data, chip enables, the two burst-start strobes, the advance input and the write controls are all captured on the rising clock edge. The output drive gate, the sleep input and the burst-order select act without a clock.

A burst opens on one of two start strobes. The processor strobe always opens a read and is masked by the primary enable. The controller strobe opens a write when the write controls ask for one, and a read otherwise. On the cycles between strobes the burst either steps to its next address or holds its current one. A hold is how wait states are inserted.

A burst covers four words. The two low address bits follow an interleaved or a linear order. Writes are merged at byte granularity. Read data leaves through an output register.

A sleep input parks the core with its contents kept. After wake-up, start strobes are refused for two cycles. A refused strobe in that window leaves a sticky flag.

Top module: `pbsram_core`

## Requirements
- R1: After reset no burst is open, `rdata_o` is zero, `drive_o` is low and `viol_o` is low.
- R2: A strobe is accepted only if `en_n_i` is 0, both `sel_hi_i` bits are 1 and both `sel_lo_n_i` bits are 0. With any other pattern a strobe closes the burst, writes nothing and leaves the output undriven after the next edge.
- R3: When `en_n_i` is 1, the processor strobe `cpu_start_n_i` = 0 is ignored: an open burst goes on as if no strobe were present.
- R4: An accepted processor strobe always starts a read at `addr_i`, whatever the write controls show on that edge.
- R5: An accepted controller strobe `ctl_start_n_i` = 0 writes at `addr_i` on the same edge if the write condition holds, and otherwise starts a read there.
- R6: The write condition is `all_wr_n_i` = 0 (all eight bytes), or `lane_wr_n_i` = 0 with at least one bit of `lane_sel_n_i` at 0. Bit n of `lane_sel_n_i` (active low) enables data bits 8n to 8n+7. Bytes not enabled keep their old contents.
- R7: With no strobe accepted and a burst open, `next_n_i` = 0 moves to the next burst address. With `linear_i` = 0 the two low bits are the start bits XOR the step count (interleaved order).
- R8: With `linear_i` = 1 the two low bits are the start bits plus the step count, modulo 4. The upper address bits never change inside a burst.
- R9: With no strobe accepted and a burst open, `next_n_i` = 1 holds the current address. The write controls apply there too, so a write following a processor-started read lands on the word that was read.
- R10: A word read at one edge appears on `rdata_o` after the next edge. `drive_o` is high only in that cycle of a read and only while `drive_n_i` is 0.
- R11: `sleep_i` high on two consecutive edges puts the core to sleep from the second of them. Strobes are then ignored, the open burst is closed, `drive_o` is low, and array contents are kept.
- R12: On the first two edges that see `sleep_i` low after sleep, every start strobe is refused. Such a strobe sets `viol_o`, which stays high until reset.
- R13: The secondary enables and `en_n_i` have no effect on cycles without a start strobe. A burst keeps stepping whatever values they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 8 | Word address sampled with a start strobe |
| wdata_i | input | 64 | Write data |
| en_n_i | input | 1 | Primary chip enable, active low; also masks the processor strobe |
| sel_hi_i | input | 2 | Secondary enables that must both be high to start |
| sel_lo_n_i | input | 2 | Secondary enables that must both be low to start |
| cpu_start_n_i | input | 1 | Processor start strobe, active low, read only |
| ctl_start_n_i | input | 1 | Controller start strobe, active low, read or write |
| next_n_i | input | 1 | Advance, active low; high holds the burst address |
| all_wr_n_i | input | 1 | Write all bytes, active low |
| lane_wr_n_i | input | 1 | Qualifies the per-byte write selects, active low |
| lane_sel_n_i | input | 8 | Per-byte write selects, active low, bit n for byte n |
| drive_n_i | input | 1 | Output drive request, active low, unclocked |
| sleep_i | input | 1 | Sleep request, active high |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata_o | output | 64 | Registered read data |
| drive_o | output | 1 | High when `rdata_o` should be driven onto the bus |
| viol_o | output | 1 | Sticky flag for a strobe seen during wake-up recovery |

## Verification
The assertions assume the burst order select is held steady while a burst holds its address. They also assume the inputs are at known values once reset is released. The bench changes `linear_i` only at the start of a burst, and changes every input half a cycle away from the sampling edge. The bench also never asserts a processor start and a controller start with a valid enable pattern on the same edge. So the assertions on strobe handling see only one accepted start per edge.

// File: rtl/pbsram_pkg.sv
// Package: shared types of the pipelined burst SRAM control core.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pbsram_pkg;

    // Access performed by the core on one clock edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/pbsram_burst_ctr.sv
// Burst address generator: keeps the start address of the open burst and
// a step count, and derives the current and the next burst address in
// interleaved (XOR) or linear (add, wrapping) order.
// Assumes load and step are never high together.
module pbsram_burst_ctr #(
    parameter int AW = 8,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          linear_i,
    output logic [AW-1:0] cur_addr_o,
    output logic [AW-1:0] nxt_addr_o
);

    logic [AW-1:0] base_q;
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] cnt_nxt;
    logic [LW-1:0] cur_lo;
    logic [LW-1:0] nxt_lo;

    // Base address and step count of the open burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            base_q <= load_addr_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            cnt_q  <= cnt_nxt;
        end
    end

    // Low address bits in the selected burst order.
    always_comb begin
        cnt_nxt = cnt_q + 1'b1;
        if (linear_i) begin
            cur_lo = base_q[LW-1:0] + cnt_q;
            nxt_lo = base_q[LW-1:0] + cnt_nxt;
        end else begin
            cur_lo = base_q[LW-1:0] ^ cnt_q;
            nxt_lo = base_q[LW-1:0] ^ cnt_nxt;
        end
    end

    assign cur_addr_o = {base_q[AW-1:LW], cur_lo};
    assign nxt_addr_o = {base_q[AW-1:LW], nxt_lo};

    // R9: a held burst keeps its address while the order select is steady.
    p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(cur_addr_o) || !$stable(linear_i)));

    // R8: the upper address bits never move inside a burst.
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (cur_addr_o[AW-1:LW] == $past(cur_addr_o[AW-1:LW])));

endmodule

// File: rtl/pbsram_ctrl.sv
// Cycle decoder: qualifies the two start strobes against the chip enables,
// opens, steps, holds or closes the burst, derives the byte write mask, and
// runs the sleep entry, the two-edge wake-up recovery and the sticky
// violation flag.
// Assumes sleep_i is already free of glitches at the clock edge.
module pbsram_ctrl
    import pbsram_pkg::*;
#(
    parameter int BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n_i,
    input  logic [1:0]       sel_hi_i,
    input  logic [1:0]       sel_lo_n_i,
    input  logic             cpu_start_n_i,
    input  logic             ctl_start_n_i,
    input  logic             next_n_i,
    input  logic             all_wr_n_i,
    input  logic             lane_wr_n_i,
    input  logic [BYTES-1:0] lane_sel_n_i,
    input  logic             sleep_i,
    output logic             load_o,
    output logic             step_o,
    output op_e              op_o,
    output logic [BYTES-1:0] wmask_o,
    output logic             asleep_o,
    output logic             viol_o
);

    logic slp_q, asleep_q, rec_q, act_q, viol_q;
    logic act_d;
    logic sel_ok, cpu_go, ctl_go, strobe, wr_cond;
    logic sleeping, recov, run;

    // Byte write mask: the global write wins over the per-byte selects.
    always_comb begin
        if (!all_wr_n_i)       wmask_o = '1;
        else if (!lane_wr_n_i) wmask_o = ~lane_sel_n_i;
        else                   wmask_o = '0;
        wr_cond = |wmask_o;
    end

    // Strobe qualification and power state of this edge.
    always_comb begin
        sel_ok   = !en_n_i && (&sel_hi_i) && !(|sel_lo_n_i);
        cpu_go   = !cpu_start_n_i && !en_n_i;
        ctl_go   = !ctl_start_n_i;
        strobe   = cpu_go || ctl_go;
        sleeping = sleep_i && (slp_q || asleep_q);
        recov    = !sleeping && ((asleep_q && !sleep_i) || rec_q);
        run      = !sleeping && !recov;
    end

    // Burst decode: open, step, hold or close the burst.
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        op_o   = OP_IDLE;
        act_d  = act_q;
        if (sleeping) begin
            act_d = 1'b0;
        end else if (run) begin
            if (strobe) begin
                if (sel_ok) begin
                    load_o = 1'b1;
                    act_d  = 1'b1;
                    op_o   = (cpu_go || !wr_cond) ? OP_READ : OP_WRITE;
                end else begin
                    act_d  = 1'b0;
                end
            end else if (act_q) begin
                step_o = !next_n_i;
                op_o   = wr_cond ? OP_WRITE : OP_READ;
            end
        end
    end

    // State registers: sleep history, recovery, burst and violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slp_q    <= 1'b0;
            asleep_q <= 1'b0;
            rec_q    <= 1'b0;
            act_q    <= 1'b0;
            viol_q   <= 1'b0;
        end else begin
            slp_q    <= sleep_i;
            asleep_q <= sleeping;
            rec_q    <= asleep_q && !sleep_i;
            act_q    <= act_d;
            if (recov && strobe) viol_q <= 1'b1;
        end
    end

    assign asleep_o = asleep_q;
    assign viol_o   = viol_q;

    // R4: an accepted processor strobe never writes.
    p_cpu_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && run) |-> (op_o != OP_WRITE));

    // R2: a strobe with a wrong enable pattern closes the burst.
    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel_ok && run) |=> !act_q);

    // R7: stepping happens only inside an open burst.
    p_step_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> act_q);

    // R11: nothing is started or accessed while asleep.
    p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_q |-> (op_o == OP_IDLE && !load_o));

    // R12: second recovery edge refuses strobes; flag is sticky.
    p_rec_refuse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rec_q |-> !load_o);
    p_viol_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);

endmodule

// File: rtl/pbsram_array.sv
// Storage and read pipeline: one memory per byte lane written under the
// byte mask on the access edge, read address and read flag registered on
// that edge, read data registered on the following edge.
// Assumes we_i and re_i are never high together.
module pbsram_array #(
    parameter int AW    = 8,
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [BYTES-1:0]   wmask_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [BYTES*8-1:0] wdata_i,
    input  logic               re_i,
    output logic [BYTES*8-1:0] rdata_o,
    output logic               rvld_o
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = BYTES * 8;

    logic [AW-1:0] raddr_q;
    logic          re_q;
    logic [DW-1:0] lane_rd;
    logic [DW-1:0] rdata_q;
    logic          rvld_q;

    // One memory per byte lane.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        // Byte lane write under its mask bit.
        always_ff @(posedge clk) begin
            if (we_i && wmask_i[b]) lane_mem[addr_i] <= wdata_i[b*8 +: 8];
        end

        assign lane_rd[b*8 +: 8] = lane_mem[raddr_q];
    end

    // Capture the read request of this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr_q <= '0;
            re_q    <= 1'b0;
        end else begin
            re_q <= re_i;
            if (re_i) raddr_q <= addr_i;
        end
    end

    // Output register: data of the previous edge's read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rvld_q  <= 1'b0;
        end else begin
            rvld_q <= re_q;
            if (re_q) rdata_q <= lane_rd;
        end
    end

    assign rdata_o = rdata_q;
    assign rvld_o  = rvld_q;

    // R10: valid output data stems from a read two edges back.
    p_out_from_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvld_q |-> $past(re_i, 2));

endmodule

// File: rtl/pbsram_core.sv
// Top of the pipelined burst SRAM control core: ties the cycle decoder,
// the burst address generator and the lane array together and gates the
// output drive with the unclocked drive request and the sleep state.
// Assumes all clocked inputs are settled around the rising edge.
module pbsram_core
    import pbsram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr_i,
    input  logic [BYTES*8-1:0] wdata_i,
    input  logic               en_n_i,
    input  logic [1:0]         sel_hi_i,
    input  logic [1:0]         sel_lo_n_i,
    input  logic               cpu_start_n_i,
    input  logic               ctl_start_n_i,
    input  logic               next_n_i,
    input  logic               all_wr_n_i,
    input  logic               lane_wr_n_i,
    input  logic [BYTES-1:0]   lane_sel_n_i,
    input  logic               drive_n_i,
    input  logic               sleep_i,
    input  logic               linear_i,
    output logic [BYTES*8-1:0] rdata_o,
    output logic               drive_o,
    output logic               viol_o
);

    localparam int LW = 2;

    logic             load, step, asleep, rvld;
    op_e              op;
    logic [BYTES-1:0] wmask;
    logic [AW-1:0]    cur_addr, nxt_addr, acc_addr;

    pbsram_ctrl #(.BYTES(BYTES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_n_i        (en_n_i),
        .sel_hi_i      (sel_hi_i),
        .sel_lo_n_i    (sel_lo_n_i),
        .cpu_start_n_i (cpu_start_n_i),
        .ctl_start_n_i (ctl_start_n_i),
        .next_n_i      (next_n_i),
        .all_wr_n_i    (all_wr_n_i),
        .lane_wr_n_i   (lane_wr_n_i),
        .lane_sel_n_i  (lane_sel_n_i),
        .sleep_i       (sleep_i),
        .load_o        (load),
        .step_o        (step),
        .op_o          (op),
        .wmask_o       (wmask),
        .asleep_o      (asleep),
        .viol_o        (viol_o)
    );

    pbsram_burst_ctr #(.AW(AW), .LW(LW)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .step_i      (step),
        .load_addr_i (addr_i),
        .linear_i    (linear_i),
        .cur_addr_o  (cur_addr),
        .nxt_addr_o  (nxt_addr)
    );

    // Address of this edge's access: new start, next step or held word.
    always_comb begin
        if (load)      acc_addr = addr_i;
        else if (step) acc_addr = nxt_addr;
        else           acc_addr = cur_addr;
    end

    pbsram_array #(.AW(AW), .BYTES(BYTES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (op == OP_WRITE),
        .wmask_i (wmask),
        .addr_i  (acc_addr),
        .wdata_i (wdata_i),
        .re_i    (op == OP_READ),
        .rdata_o (rdata_o),
        .rvld_o  (rvld)
    );

    // Drive only valid read data, on request, and never while asleep.
    assign drive_o = rvld && !drive_n_i && !asleep;

    // R11: the output is undriven on the edge after sleep has been entered.
    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(asleep) && asleep) |-> !rvld);

endmodule

// File: tb/pbsram_core_test.sv
`timescale 1ns/1ps
module pbsram_core_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr_i;
    logic [63:0] wdata_i;
    logic        en_n_i;
    logic [1:0]  sel_hi_i, sel_lo_n_i;
    logic        cpu_start_n_i, ctl_start_n_i, next_n_i;
    logic        all_wr_n_i, lane_wr_n_i;
    logic [7:0]  lane_sel_n_i;
    logic        drive_n_i, sleep_i, linear_i;
    logic [63:0] rdata_o;
    logic        drive_o, viol_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pbsram_core uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .en_n_i(en_n_i), .sel_hi_i(sel_hi_i), .sel_lo_n_i(sel_lo_n_i),
        .cpu_start_n_i(cpu_start_n_i), .ctl_start_n_i(ctl_start_n_i),
        .next_n_i(next_n_i), .all_wr_n_i(all_wr_n_i), .lane_wr_n_i(lane_wr_n_i),
        .lane_sel_n_i(lane_sel_n_i), .drive_n_i(drive_n_i), .sleep_i(sleep_i),
        .linear_i(linear_i), .rdata_o(rdata_o), .drive_o(drive_o), .viol_o(viol_o)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [63:0] d;
        logic        gw_n;
        logic        bw_n;
        logic [7:0]  be_n;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, 8'hFF, 64'h0123_4567_89AB_CDEF},
        '{8'h10, 64'hFFFF_FFFF_FFFF_FFAA, 1'b1, 1'b0, 8'hFE, 64'h0123_4567_89AB_CDAA},
        '{8'h10, 64'h5500_0000_0000_0000, 1'b1, 1'b0, 8'h7F, 64'h5523_4567_89AB_CDAA},
        '{8'h10, 64'h0000_0000_0000_0000, 1'b1, 1'b1, 8'h00, 64'h5523_4567_89AB_CDAA},
        '{8'h10, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 8'hFF, 64'h5523_4567_89AB_CDAA},
        '{8'h20, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b1, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D},
        '{8'h20, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 8'hC3, 64'hDEAD_2222_3333_F00D},
        '{8'hFF, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 1'b1, 8'hFF, 64'hA5A5_5A5A_0F0F_F0F0}
    };

    localparam logic [63:0] W10 = 64'h5523_4567_89AB_CDAA;
    localparam logic [63:0] W20 = 64'hDEAD_2222_3333_F00D;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        addr_i = 8'h00; wdata_i = '0; en_n_i = 1'b0; sel_hi_i = 2'b11;
        sel_lo_n_i = 2'b00; cpu_start_n_i = 1'b1; ctl_start_n_i = 1'b1;
        next_n_i = 1'b1; all_wr_n_i = 1'b1; lane_wr_n_i = 1'b1;
        lane_sel_n_i = 8'hFF; drive_n_i = 1'b0;
    endtask

    // Controller strobe at the next edge; returns at the negedge after it.
    task automatic ctl_start(input logic [7:0] a, input logic [63:0] d,
                             input logic gw, input logic bw, input logic [7:0] be);
        addr_i = a; wdata_i = d; all_wr_n_i = gw; lane_wr_n_i = bw;
        lane_sel_n_i = be; ctl_start_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        ctl_start_n_i = 1'b1; all_wr_n_i = 1'b1; lane_wr_n_i = 1'b1;
        lane_sel_n_i = 8'hFF;
    endtask

    task automatic read_word(input string tag, input logic [7:0] a, input logic [63:0] exp);
        ctl_start(a, '0, 1'b1, 1'b1, 8'hFF);
        @(posedge clk); @(negedge clk);
        chk(tag, rdata_o, exp);
        chk(tag, {63'd0, drive_o}, 64'd1);
    endtask

    task automatic run_burst(input logic lin);
        linear_i = lin;
        ctl_start(8'h41, '0, 1'b1, 1'b1, 8'hFF);
        next_n_i = 1'b0;
        // R3 and R13: strobe with primary enable high, bad secondary enables
        cpu_start_n_i = 1'b0; en_n_i = 1'b1; sel_hi_i = 2'b01; sel_lo_n_i = 2'b10;
        for (int i = 0; i < 5; i++) begin
            int lo;
            @(posedge clk); @(negedge clk);
            lo = (i < 4) ? i : 3;
            lo = lin ? ((1 + lo) % 4) : (1 ^ lo);
            chk(lin ? "R8 R3 R13 linear burst" : "R7 R3 R13 interleaved burst (R9 hold at end)",
                rdata_o, 64'hB000_0000_0000_0000 + 64'(lo));
            if (i == 2) next_n_i = 1'b1;
        end
        defaults();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual run still going, expected completion");
        summary();
        $finish;
    end

    initial begin
        defaults();
        sleep_i = 1'b0; linear_i = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdata", rdata_o, 64'd0);
        chk("R1 drive", {63'd0, drive_o}, 64'd0);
        chk("R1 viol", {63'd0, viol_o}, 64'd0);

        // Vector table: write (or not) under the given controls, then read back.
        for (int v = 0; v < NV; v++) begin
            ctl_start(VECS[v].a, VECS[v].d, VECS[v].gw_n, VECS[v].bw_n, VECS[v].be_n);
            read_word($sformatf("R5 R6 vector %0d", v), VECS[v].a, VECS[v].exp);
        end

        // R4: processor strobe with global write low only reads.
        addr_i = 8'h10; wdata_i = '0; all_wr_n_i = 1'b0; cpu_start_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        cpu_start_n_i = 1'b1; all_wr_n_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R4 read data", rdata_o, W10);
        read_word("R4 no write", 8'h10, W10);

        // R9: write on a held edge after a processor start lands on that word.
        addr_i = 8'h30; cpu_start_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        cpu_start_n_i = 1'b1; next_n_i = 1'b1; all_wr_n_i = 1'b0;
        wdata_i = 64'h3C3C_C3C3_0000_FFFF;
        @(posedge clk); @(negedge clk);
        all_wr_n_i = 1'b1;
        read_word("R9 held write", 8'h30, 64'h3C3C_C3C3_0000_FFFF);

        // Bursts over 0x40..0x43 in both orders.
        for (int i = 0; i < 4; i++)
            ctl_start(8'(8'h40 + i), 64'hB000_0000_0000_0000 + 64'(i), 1'b0, 1'b1, 8'hFF);
        run_burst(1'b0);
        run_burst(1'b1);
        linear_i = 1'b0;

        // R2: wrong enable pattern on a write strobe deselects and writes nothing.
        sel_hi_i = 2'b10;
        ctl_start(8'h20, '1, 1'b0, 1'b1, 8'hFF);
        sel_hi_i = 2'b11;
        @(posedge clk); @(negedge clk);
        chk("R2 undriven after deselect", {63'd0, drive_o}, 64'd0);
        read_word("R2 no write", 8'h20, W20);
        sel_lo_n_i = 2'b01; addr_i = 8'h10; cpu_start_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        defaults();
        @(posedge clk); @(negedge clk);
        chk("R2 processor deselect", {63'd0, drive_o}, 64'd0);

        // R10: latency and drive gating.
        en_n_i = 1'b1; ctl_start_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        defaults();
        addr_i = 8'h10; ctl_start_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        ctl_start_n_i = 1'b1;
        chk("R10 not yet driven", {63'd0, drive_o}, 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R10 driven one edge later", {63'd0, drive_o}, 64'd1);
        chk("R10 data", rdata_o, W10);
        drive_n_i = 1'b1; #1;
        chk("R10 drive request off", {63'd0, drive_o}, 64'd0);
        drive_n_i = 1'b0;

        // R11: sleep keeps contents, ignores strobes without a violation.
        sleep_i = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R11 undriven asleep", {63'd0, drive_o}, 64'd0);
        addr_i = 8'h10; wdata_i = '0; all_wr_n_i = 1'b0; ctl_start_n_i = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R11 no violation asleep", {63'd0, viol_o}, 64'd0);
        defaults(); sleep_i = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R11 no violation quiet wake", {63'd0, viol_o}, 64'd0);
        read_word("R11 contents kept", 8'h10, W10);

        // R12: a write strobe on the first recovery edge is refused and flagged.
        sleep_i = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        sleep_i = 1'b0; addr_i = 8'h10; wdata_i = '0; all_wr_n_i = 1'b0;
        ctl_start_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        defaults();
        chk("R12 flag set", {63'd0, viol_o}, 64'd1);
        @(posedge clk); @(negedge clk);
        read_word("R12 refused write", 8'h10, W10);
        chk("R12 flag sticky", {63'd0, viol_o}, 64'd1);

        summary();
        $finish;
    end

endmodule